// File: doc/BRIEF.md
# Open-Drain Reset Line Sequencer

This block owns a bidirectional reset line that a pull-up holds high. It can only pull the line low, never push it high. When power comes up, when an internal reset request arrives, or when something outside pulls the line low, it holds the line low for a fixed interval and then lets it go. On the clock edge where it lets go it captures the configuration inputs: a bus-error strap, a breakpoint strap and a data-bus strap word. It then waits a short settling time and reads the line through a synchronizer. If the line is still low, it waits a longer time and reads it again. If the line is low at that second read too, it starts the whole sequence again. The external bus is handed over, and the internal module reset is dropped, only after a read that finds the line high.

After power-on the block sits in `ST_LOCK_WAIT` with the line pulled low until the clock synthesizer reports lock. In external-clock mode it does not wait for lock. The states and their transitions are:

- `ST_LOCK_WAIT` goes to `ST_DRIVE` on lock or in external-clock mode.
- `ST_DRIVE` goes to `ST_SETTLE` when its interval ends. The straps are captured on this transition.
- `ST_SETTLE` goes to `ST_RUN` if the line reads high. If it reads low, it goes to `ST_RETRY`.
- `ST_RETRY` goes to `ST_RUN` if the line reads high. If it reads low, it goes back to `ST_DRIVE`.
- `ST_RUN` goes to `ST_DRIVE` if the synchronized line reads low.
- A reset request in any state except `ST_LOCK_WAIT` returns to `ST_DRIVE` and restarts its interval.

Top module: `rstline_seq`

## Requirements
- R1: While `por_n` is low, and afterwards in `ST_LOCK_WAIT`, the outputs are `pad_drive_low`=1, `mod_rst`=1, `bus_release`=0 and all captured straps 0. The block stays in `ST_LOCK_WAIT` until `pll_lock`=1, and `soft_rst_req` has no effect there.
- R2: With `ext_clk_mode`=1, the block leaves `ST_LOCK_WAIT` on the first clock after power-on without waiting for `pll_lock`.
- R3: Each `ST_DRIVE` phase keeps `pad_drive_low`=1 for exactly ASSERT_CYC clock cycles, and then `pad_drive_low` returns to 0.
- R4: `cfg_berr_q`, `cfg_bkpt_q` and `cfg_data_q` take the strap inputs on the clock edge where `pad_drive_low` falls. They hold that value until the next such edge.
- R5: The line is read at the end of the SETTLE_CYC-th cycle after release, using the value from the two-flop synchronizer. If it reads high, `bus_release` becomes 1 and `mod_rst` becomes 0 on the next cycle.
- R6: If the first read is low, the block waits RETRY_CYC further cycles and reads again. A high level then enters `ST_RUN`.
- R7: If the second read is also low, a new ASSERT_CYC-cycle drive phase starts.
- R8: `soft_rst_req`=1 in `ST_DRIVE`, `ST_SETTLE`, `ST_RETRY` or `ST_RUN` makes the next cycle the first cycle of a full drive phase.
- R9: In `ST_RUN`, a low synchronized line level returns the block to `ST_DRIVE`.
- R10: `bus_release` is 0, and `mod_rst` is 1, from the start of any reset until a successful high read. `mod_rst` is held for at least four cycles each time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst_req | input | 1 | Internal reset request |
| pll_lock | input | 1 | Clock synthesizer lock indication |
| ext_clk_mode | input | 1 | 1 = external clock, skip the lock wait |
| cfg_berr_in | input | 1 | Bus-error strap |
| cfg_bkpt_in | input | 1 | Breakpoint strap |
| cfg_data_in | input | CFG_W | Data-bus strap word |
| pad_in | input | 1 | Level sensed on the reset line |
| pad_drive_low | output | 1 | 1 = pull the reset line low |
| cfg_berr_q | output | 1 | Captured bus-error strap |
| cfg_bkpt_q | output | 1 | Captured breakpoint strap |
| cfg_data_q | output | CFG_W | Captured data-bus strap word |
| mod_rst | output | 1 | Internal module reset, active high |
| bus_release | output | 1 | External bus handed over, reset vector may be fetched |

## Verification
The bench builds the block with ASSERT_CYC=16, SETTLE_CYC=4 and RETRY_CYC=9 instead of 512/10/180. With these values, the lock wait, release during retry, a double-low restart, requests in each phase and a line pulled low during run all fit in a few hundred cycles. SETTLE_CYC=4 still exceeds the synchronizer depth, so the first read always sees the released line. The behavioural model tracks the line level, including the bench's external hold, through its own two-deep delay.

// File: rtl/rstline_pkg.sv
package rstline_pkg;

    typedef enum logic [2:0] {
        ST_LOCK_WAIT = 3'd0,
        ST_DRIVE     = 3'd1,
        ST_SETTLE    = 3'd2,
        ST_RETRY     = 3'd3,
        ST_RUN       = 3'd4
    } seq_state_e;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rstline_sync.sv
module rstline_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= '0;
                else        sh <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= '0;
                else        sh <= {sh[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh[STAGES-1];
endmodule

// File: rtl/rstline_ctr.sv
module rstline_ctr #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end

    assign done = (cnt == limit - 1'b1);
endmodule

// File: rtl/rstline_cfg_latch.sv
module rstline_cfg_latch #(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/rstline_seq.sv
module rstline_seq
    import rstline_pkg::*;
#(
    parameter int ASSERT_CYC  = 512,
    parameter int SETTLE_CYC  = 10,
    parameter int RETRY_CYC   = 180,
    parameter int CFG_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             soft_rst_req,
    input  logic             pll_lock,
    input  logic             ext_clk_mode,
    input  logic             cfg_berr_in,
    input  logic             cfg_bkpt_in,
    input  logic [CFG_W-1:0] cfg_data_in,
    input  logic             pad_in,
    output logic             pad_drive_low,
    output logic             cfg_berr_q,
    output logic             cfg_bkpt_q,
    output logic [CFG_W-1:0] cfg_data_q,
    output logic             mod_rst,
    output logic             bus_release
);
    localparam int unsigned MAXC  = max3(ASSERT_CYC, SETTLE_CYC, RETRY_CYC);
    localparam int          CW    = $clog2(MAXC + 1);
    localparam int          LW    = CFG_W + 2;
    localparam logic [CW-1:0] LIM_DRIVE  = CW'(ASSERT_CYC);
    localparam logic [CW-1:0] LIM_SETTLE = CW'(SETTLE_CYC);
    localparam logic [CW-1:0] LIM_RETRY  = CW'(RETRY_CYC);
    localparam int MIN_MOD_RST = 4;

    seq_state_e      state, nxt;
    logic            pad_sync;
    logic            ivl_done;
    logic            ivl_clr;
    logic [CW-1:0]   ivl_limit;
    logic            restart;
    logic            load_cfg;
    logic [LW-1:0]   cfg_bus;

    rstline_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     (pad_in),
        .q     (pad_sync)
    );

    rstline_ctr #(.W(CW)) u_ctr (
        .clk   (clk),
        .rst_n (por_n),
        .clr   (ivl_clr),
        .limit (ivl_limit),
        .done  (ivl_done)
    );

    rstline_cfg_latch #(.DW(LW)) u_cfg (
        .clk   (clk),
        .rst_n (por_n),
        .load  (load_cfg),
        .d     ({cfg_berr_in, cfg_bkpt_in, cfg_data_in}),
        .q     (cfg_bus)
    );

    assign cfg_berr_q = cfg_bus[LW-1];
    assign cfg_bkpt_q = cfg_bus[LW-2];
    assign cfg_data_q = cfg_bus[CFG_W-1:0];

    assign restart = soft_rst_req && (state != ST_LOCK_WAIT);

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_LOCK_WAIT: if (pll_lock || ext_clk_mode) nxt = ST_DRIVE;
            ST_DRIVE:     if (ivl_done) nxt = ST_SETTLE;
            ST_SETTLE:    if (ivl_done) nxt = pad_sync ? ST_RUN : ST_RETRY;
            ST_RETRY:     if (ivl_done) nxt = pad_sync ? ST_RUN : ST_DRIVE;
            ST_RUN:       if (!pad_sync) nxt = ST_DRIVE;
            default:      nxt = ST_LOCK_WAIT;
        endcase
        if (restart) nxt = ST_DRIVE;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= ST_LOCK_WAIT;
        else        state <= nxt;
    end

    // outputs and interval control
    always_comb begin
        pad_drive_low = 1'b0;
        mod_rst       = 1'b1;
        bus_release   = 1'b0;
        ivl_limit     = LIM_DRIVE;
        unique case (state)
            ST_LOCK_WAIT: pad_drive_low = 1'b1;
            ST_DRIVE:     pad_drive_low = 1'b1;
            ST_SETTLE:    ivl_limit = LIM_SETTLE;
            ST_RETRY:     ivl_limit = LIM_RETRY;
            ST_RUN: begin
                mod_rst     = 1'b0;
                bus_release = 1'b1;
            end
            default: pad_drive_low = 1'b1;
        endcase
        ivl_clr  = restart || (nxt != state) ||
                   (state == ST_LOCK_WAIT) || (state == ST_RUN);
        load_cfg = (state == ST_DRIVE) && (nxt == ST_SETTLE);
    end

    // ---------------- assertion support and properties ----------------
    logic [CW-1:0] asr_len;
    logic [3:0]    mrst_len;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            asr_len  <= '0;
            mrst_len <= '0;
        end else begin
            asr_len  <= (state == ST_DRIVE && !soft_rst_req) ? asr_len + 1'b1 : '0;
            if (!mod_rst)             mrst_len <= '0;
            else if (mrst_len != 4'hF) mrst_len <= mrst_len + 1'b1;
        end
    end

    p_lock_hold_r1: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_LOCK_WAIT && !pll_lock && !ext_clk_mode) |=> state == ST_LOCK_WAIT);

    p_extclk_skip_r2: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_LOCK_WAIT && ext_clk_mode) |=> pad_drive_low && state == ST_DRIVE);

    p_drive_len_r3: assert property (@(posedge clk) disable iff (!por_n)
        $fell(pad_drive_low) |-> asr_len == CW'(ASSERT_CYC));

    p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
        !$fell(pad_drive_low) |-> $stable(cfg_bus));

    p_run_high_r5: assert property (@(posedge clk) disable iff (!por_n)
        $rose(bus_release) |-> $past(pad_sync));

    p_retry_low_r7: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_RETRY && ivl_done && !pad_sync) |=> pad_drive_low);

    p_req_restart_r8: assert property (@(posedge clk) disable iff (!por_n)
        restart |=> pad_drive_low && !bus_release);

    p_ext_pull_r9: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_RUN && !pad_sync && !soft_rst_req) |=> pad_drive_low);

    p_bus_held_r10: assert property (@(posedge clk) disable iff (!por_n)
        pad_drive_low |-> (!bus_release && mod_rst));

    p_modrst_min_r10: assert property (@(posedge clk) disable iff (!por_n)
        $fell(mod_rst) |-> mrst_len >= 4'(MIN_MOD_RST));

endmodule

// File: tb/rstline_seq_tb.sv
`timescale 1ns/1ps
module rstline_seq_tb;
    localparam int A  = 16;
    localparam int S  = 4;
    localparam int RT = 9;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          soft_rst_req = 1'b0;
    logic          pll_lock = 1'b0;
    logic          ext_clk_mode = 1'b0;
    logic          cfg_berr_in = 1'b0;
    logic          cfg_bkpt_in = 1'b0;
    logic [CW-1:0] cfg_data_in = '0;
    logic          ext_hold = 1'b0;
    logic          pad_in;
    logic          pad_drive_low, cfg_berr_q, cfg_bkpt_q, mod_rst, bus_release;
    logic [CW-1:0] cfg_data_q;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    // open-drain line: pulled up unless the block or the outside world pulls it low
    assign pad_in = ~(pad_drive_low | ext_hold);

    rstline_seq #(.ASSERT_CYC(A), .SETTLE_CYC(S), .RETRY_CYC(RT), .CFG_W(CW)) u_dut (
        .clk(clk), .por_n(por_n), .soft_rst_req(soft_rst_req), .pll_lock(pll_lock),
        .ext_clk_mode(ext_clk_mode), .cfg_berr_in(cfg_berr_in), .cfg_bkpt_in(cfg_bkpt_in),
        .cfg_data_in(cfg_data_in), .pad_in(pad_in), .pad_drive_low(pad_drive_low),
        .cfg_berr_q(cfg_berr_q), .cfg_bkpt_q(cfg_bkpt_q), .cfg_data_q(cfg_data_q),
        .mod_rst(mod_rst), .bus_release(bus_release));

    // behavioural model: phase 0 lock wait, 1 drive, 2 settle, 3 retry, 4 run
    int          ph = 0;
    int          left = 0;
    bit          seen_q[$];
    logic [17:0] m_cfg = '0;

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ph = 0; left = 0; m_cfg = '0;
            seen_q = '{1'b0, 1'b0};
        end else begin
            bit lvl, smp;
            lvl = !((ph <= 1) || ext_hold);
            smp = seen_q[0];
            void'(seen_q.pop_front());
            seen_q.push_back(lvl);
            if (ph == 0) begin
                if (ext_clk_mode || pll_lock) begin ph = 1; left = A; end
            end else if (soft_rst_req) begin
                ph = 1; left = A;
            end else if (ph == 1) begin
                left--;
                if (left == 0) begin ph = 2; left = S; m_cfg = {cfg_berr_in, cfg_bkpt_in, cfg_data_in}; end
            end else if (ph == 2) begin
                left--;
                if (left == 0) begin
                    if (smp) ph = 4; else begin ph = 3; left = RT; end
                end
            end else if (ph == 3) begin
                left--;
                if (left == 0) begin
                    if (smp) ph = 4; else begin ph = 1; left = A; end
                end
            end else if (!smp) begin
                ph = 1; left = A;
            end
        end
    end

    task automatic chk(input string fld, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s/%s at %0t: actual %0h expected %0h", cur_req, fld, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #1;
        chk("R3 pad_drive_low", 32'(pad_drive_low), 32'(ph <= 1));
        chk("R10 mod_rst",      32'(mod_rst),       32'(ph != 4));
        chk("R5 bus_release",   32'(bus_release),   32'(ph == 4));
        chk("R4 cfg",           32'({cfg_berr_q, cfg_bkpt_q, cfg_data_q}), 32'(m_cfg));
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req();
        @(negedge clk); soft_rst_req = 1'b1;
        @(negedge clk); soft_rst_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state and lock wait, request ignored
        cur_req = "R1";
        cyc(3); por_n = 1'b1;
        cyc(8); pulse_req(); cyc(10);
        // R3 R4 R5: lock arrives, straps captured on release, clean high read
        cur_req = "R3";
        cfg_berr_in = 1'b1; cfg_data_in = 16'hA5C3;
        @(negedge clk); pll_lock = 1'b1;
        cyc(10); cfg_bkpt_in = 1'b1; cfg_data_in = 16'h5A3C;
        cur_req = "R5"; cyc(30);
        // R4: strap changes during run ignored
        cur_req = "R4";
        cfg_berr_in = 1'b0; cfg_data_in = 16'h0F0F; cyc(10);
        // R6: held low past first read, released during retry
        cur_req = "R6";
        ext_hold = 1'b1; pulse_req(); cyc(A + S + 3);
        ext_hold = 1'b0; cyc(30);
        // R7: low at both reads, full restart
        cur_req = "R7";
        cfg_data_in = 16'h1234;
        ext_hold = 1'b1; pulse_req(); cyc(A + S + RT + 5);
        ext_hold = 1'b0; cfg_data_in = 16'hBEEF; cyc(40);
        // R8: request during run, settle and drive
        cur_req = "R8";
        pulse_req(); cyc(A + 1); pulse_req(); cyc(5); pulse_req(); cyc(40);
        // R9: outside pull-low during run
        cur_req = "R9";
        ext_hold = 1'b1; cyc(3); ext_hold = 1'b0; cyc(40);
        // R2: external clock mode skips lock wait
        cur_req = "R2";
        @(negedge clk); por_n = 1'b0; pll_lock = 1'b0; ext_clk_mode = 1'b1;
        cyc(3); por_n = 1'b1; cyc(40);
        cur_req = "R10"; cyc(5);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule